// File: doc/BRIEF.md
# Character LCD Bus-Side Controller

This block models a character display controller as seen from a processor's external bus. It answers at two adjacent byte offsets: offset 0 takes commands and returns status, and offset 1 takes and returns data. It keeps a 128-byte display memory, a 7-bit address cursor, and latches for the last data byte and the last command byte. The decoded commands are set-address, clear and home. A data write stores its byte at the cursor and advances the cursor.

A separate read-only view port lets display-side logic fetch the character at a given line and column of a 16-column, 4-line panel. The four lines begin at display addresses 0x00, 0x40, 0x10 and 0x50, in that line order. The view port is combinational. It reflects the memory as it stands after the most recent clock edge.

Top module: `lcd_busctl`

## Requirements
- R1: After reset every display memory byte reads 0x20, the cursor is 0, and the data latch and command latch are both 0x00.
- R2: A write takes effect only on a clock edge with `bus_cs` and `bus_wr` both high. `bus_sel`=0 selects the command/status register and `bus_sel`=1 selects the data register. A write strobe with `bus_cs` low changes nothing.
- R3: A command byte with bit 7 set loads the cursor with bits 6:0 of that byte.
- R4: Command 0x01 sets all 128 memory bytes to 0x20 and the cursor to 0 in one clock.
- R5: Command 0x02 sets the cursor to 0 and leaves memory unchanged.
- R6: A data write stores the byte at the cursor and then increments the cursor modulo 128, so 0x7F is followed by 0x00.
- R7: A read at offset 0 returns the cursor in bits 6:0, and bit 7 (busy) is always 0.
- R8: A read at offset 1 returns the last byte written to the data register, not the memory contents.
- R9: The view port returns memory byte (start + column) mod 128. The start is 0x00 for line 0, 0x40 for line 1, 0x10 for line 2 and 0x50 for line 3. It is combinational, so a write appears there after the edge that performs it.
- R10: A view line index of 4 or more sets `view_err` and returns 0x20. Lines 0 to 3 clear `view_err`.
- R11: Every command byte, decoded or not, is captured in the command latch, which is visible on `last_cmd`.
- R12: Command bytes other than 0x01, 0x02 and those with bit 7 set leave the cursor and memory unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_cs | input | 1 | Access select |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_sel | input | 1 | Register offset: 0 command/status, 1 data |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Read byte for the selected offset |
| last_cmd | output | 8 | Command latch |
| view_line | input | 3 | Panel line index for the view port |
| view_col | input | 4 | Panel column index for the view port |
| view_char | output | 8 | Character at the addressed line and column |
| view_err | output | 1 | Line index out of range |

## Verification
The view port and the bus write path can touch the same memory byte in the same cycle. The bench points the view at a cell and, in that same cycle, issues a data write to that cell and later a clear command. Before the edge, the view must still show the old byte. After the edge, it must show the newly written byte, or 0x20 after the clear. A single cycle of lag in either direction counts as a failure.

// File: rtl/lcd_busctl.sv
module lcd_busctl #(
  parameter int          RAM_AW = 7,
  parameter int          COL_W  = 4,
  parameter int          LINE_W = 3,
  parameter int          LINES  = 4,
  parameter logic [7:0]  BLANK  = 8'h20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_cs,
  input  logic              bus_wr,
  input  logic              bus_sel,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic [7:0]        last_cmd,
  input  logic [LINE_W-1:0] view_line,
  input  logic [COL_W-1:0]  view_col,
  output logic [7:0]        view_char,
  output logic              view_err
);
  localparam int DEPTH = 1 << RAM_AW;
  localparam logic [7:0] CMD_CLEAR = 8'h01;
  localparam logic [7:0] CMD_HOME  = 8'h02;

  logic [7:0]        mem [DEPTH];
  logic [RAM_AW-1:0] cursor;
  logic [7:0]        dlat;
  logic [RAM_AW-1:0] line_base;
  logic [RAM_AW-1:0] view_addr;

  wire wr_cmd = bus_cs & bus_wr & ~bus_sel;
  wire wr_dat = bus_cs & bus_wr &  bus_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= BLANK;
      cursor   <= '0;
      dlat     <= '0;
      last_cmd <= '0;
    end else if (wr_cmd) begin
      last_cmd <= bus_wdata;
      if (bus_wdata[7]) begin
        cursor <= bus_wdata[RAM_AW-1:0];
      end else if (bus_wdata == CMD_CLEAR) begin
        for (int i = 0; i < DEPTH; i++) mem[i] <= BLANK;
        cursor <= '0;
      end else if (bus_wdata == CMD_HOME) begin
        cursor <= '0;
      end
    end else if (wr_dat) begin
      dlat        <= bus_wdata;
      mem[cursor] <= bus_wdata;
      cursor      <= cursor + 1'b1;
    end
  end

  assign bus_rdata = bus_sel ? dlat : 8'(cursor);

  always_comb begin
    case (view_line[1:0])
      2'd0:    line_base = RAM_AW'(8'h00);
      2'd1:    line_base = RAM_AW'(8'h40);
      2'd2:    line_base = RAM_AW'(8'h10);
      default: line_base = RAM_AW'(8'h50);
    endcase
  end

  assign view_addr = line_base + RAM_AW'(view_col);
  assign view_err  = 32'(view_line) >= LINES;
  assign view_char = view_err ? BLANK : mem[view_addr];
endmodule

module lcd_busctl_chk #(
  parameter int RAM_AW = 7,
  parameter int LINE_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_cs,
  input logic              bus_wr,
  input logic              bus_sel,
  input logic [7:0]        bus_wdata,
  input logic [7:0]        bus_rdata,
  input logic [7:0]        last_cmd,
  input logic [RAM_AW-1:0] cursor,
  input logic [LINE_W-1:0] view_line,
  input logic [7:0]        view_char,
  input logic              view_err
);
  wire cmd_w = bus_cs & bus_wr & ~bus_sel;
  wire dat_w = bus_cs & bus_wr &  bus_sel;

  assert_setaddr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_w && bus_wdata[7] |=> cursor == $past(bus_wdata[RAM_AW-1:0]));
  assert_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_w && bus_wdata == 8'h01 |=> cursor == '0);
  assert_home_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_w && bus_wdata == 8'h02 |=> cursor == '0);
  assert_incr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    dat_w |=> cursor == RAM_AW'($past(cursor) + 1'b1));
  assert_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_sel |-> bus_rdata[7] == 1'b0);
  assert_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
    view_line > 3'(3) |-> view_err && view_char == 8'h20);
  assert_latch_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_w |=> last_cmd == $past(bus_wdata));
  assert_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_cs && bus_wr) |=> $stable(cursor) && $stable(last_cmd));
  assert_other_R12: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_w && !bus_wdata[7] && bus_wdata != 8'h01 && bus_wdata != 8'h02 |=> $stable(cursor));
endmodule

bind lcd_busctl lcd_busctl_chk #(.RAM_AW(RAM_AW), .LINE_W(LINE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_cs(bus_cs), .bus_wr(bus_wr), .bus_sel(bus_sel),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .last_cmd(last_cmd), .cursor(cursor),
  .view_line(view_line), .view_char(view_char), .view_err(view_err)
);

// File: tb/sim_lcd_busctl.sv
module sim_lcd_busctl;
  logic       clk = 0, rst_n = 0;
  logic       bus_cs = 0, bus_wr = 0, bus_sel = 0;
  logic [7:0] bus_wdata = 0;
  logic [7:0] bus_rdata, last_cmd, view_char;
  logic [2:0] view_line = 0;
  logic [3:0] view_col = 0;
  logic       view_err;
  int n_run = 0, n_fail = 0;

  always #10 clk = ~clk;

  lcd_busctl u0 (.*);

  initial begin
    #2000000;
    n_fail++;
    $display("FAIL watchdog: act=hung exp=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: act=%02h exp=%02h", tag, act, exp);
    end
  endtask

  task automatic wr(logic sel, logic [7:0] d);
    @(negedge clk);
    bus_cs = 1; bus_wr = 1; bus_sel = sel; bus_wdata = d;
    @(negedge clk);
    bus_cs = 0; bus_wr = 0;
  endtask

  task automatic rd(logic sel, output logic [7:0] d);
    @(negedge clk);
    bus_cs = 1; bus_wr = 0; bus_sel = sel;
    #3 d = bus_rdata;
    bus_cs = 0;
  endtask

  task automatic view(int ln, int col, output logic [7:0] c);
    view_line = 3'(ln); view_col = 4'(col);
    #1 c = view_char;
  endtask

  task automatic t_reset;
    logic [7:0] v;
    rd(0, v); check("R1 cursor", v, 8'h00);
    rd(1, v); check("R1 data latch", v, 8'h00);
    check("R1 cmd latch", last_cmd, 8'h00);
    for (int l = 0; l < 4; l++) begin
      view(l, 0, v);  check("R1 blank col0", v, 8'h20);
      view(l, 15, v); check("R1 blank col15", v, 8'h20);
    end
  endtask

  task automatic t_write;
    logic [7:0] v;
    wr(0, 8'h80); wr(1, "A"); wr(1, "B");
    view(0, 0, v); check("R6 first", v, "A");
    view(0, 1, v); check("R6 second", v, "B");
    rd(0, v); check("R7 status", v, 8'h02);
    rd(1, v); check("R8 data latch", v, "B");
  endtask

  task automatic t_lines;
    logic [7:0] v;
    wr(0, 8'hC0); wr(1, "1");
    wr(0, 8'h90); wr(1, "2");
    wr(0, 8'hD0); wr(1, "3");
    rd(0, v); check("R3 status after 0xD0", v, 8'h51);
    wr(0, 8'h8F); wr(1, "x");
    view(1, 0, v);  check("R9 line1", v, "1");
    view(2, 0, v);  check("R9 line2", v, "2");
    view(3, 0, v);  check("R9 line3", v, "3");
    view(0, 15, v); check("R9 line0 col15", v, "x");
    check("R10 err low", {7'd0, view_err}, 8'h00);
  endtask

  task automatic t_wrap;
    logic [7:0] v;
    wr(0, 8'hFF); wr(1, "Z");
    rd(0, v); check("R6 wrap", v, 8'h00);
    wr(1, "Q");
    view(0, 0, v); check("R6 after wrap", v, "Q");
  endtask

  task automatic t_home;
    logic [7:0] v;
    wr(0, 8'h85); wr(1, "H");
    wr(0, 8'h02);
    rd(0, v); check("R5 cursor", v, 8'h00);
    view(0, 5, v); check("R5 ram kept", v, "H");
    check("R11 latch home", last_cmd, 8'h02);
  endtask

  task automatic t_other;
    logic [7:0] v;
    wr(0, 8'h85);
    wr(0, 8'h33);
    rd(0, v); check("R12 cursor kept", v, 8'h05);
    check("R11 latch undecoded", last_cmd, 8'h33);
    view(0, 5, v); check("R12 ram kept", v, "H");
    wr(0, 8'h00);
    rd(0, v); check("R12 cursor kept 0x00", v, 8'h05);
    check("R11 latch 0x00", last_cmd, 8'h00);
  endtask

  task automatic t_cs;
    logic [7:0] v;
    @(negedge clk);
    bus_cs = 0; bus_wr = 1; bus_sel = 1; bus_wdata = "K";
    @(negedge clk);
    bus_wr = 0;
    rd(0, v); check("R2 cursor", v, 8'h05);
    rd(1, v); check("R2 data latch", v, "H");
    view(0, 5, v); check("R2 ram", v, "H");
  endtask

  task automatic t_clear;
    logic [7:0] v;
    wr(0, 8'h01);
    rd(0, v); check("R4 cursor", v, 8'h00);
    view(0, 5, v); check("R4 line0", v, 8'h20);
    view(1, 0, v); check("R4 line1", v, 8'h20);
    view(3, 0, v); check("R4 line3", v, 8'h20);
    rd(1, v); check("R8 latch kept", v, "H");
  endtask

  task automatic t_err;
    logic [7:0] v;
    for (int l = 4; l < 8; l++) begin
      view(l, 0, v); check("R10 char", v, 8'h20);
      check("R10 err", {7'd0, view_err}, 8'h01);
    end
  endtask

  task automatic t_overlap;
    logic [7:0] v;
    wr(0, 8'h83);
    view(0, 3, v);
    @(negedge clk);
    bus_cs = 1; bus_wr = 1; bus_sel = 1; bus_wdata = "W";
    #3 check("R9 before edge", view_char, 8'h20);
    @(negedge clk);
    bus_cs = 0; bus_wr = 0;
    check("R9 after edge", view_char, "W");
    bus_cs = 1; bus_wr = 1; bus_sel = 0; bus_wdata = 8'h01;
    #3 check("R4 before edge", view_char, "W");
    @(negedge clk);
    bus_cs = 0; bus_wr = 0;
    check("R4 after edge", view_char, 8'h20);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset; t_write; t_lines; t_wrap; t_home; t_other;
    t_cs; t_clear; t_err; t_overlap;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule